// File: doc/BRIEF.md
# Dual-Width Flag and Status Register

This block holds a 16-bit processor status word and the arithmetic unit that drives its condition flags. One 24-bit add, subtract or compare produces two flag groups in the same cycle. The first group (overflow, carry, negative, zero) describes the full 24-bit result. The second group describes the result's low 16 bits. Both groups are written into the status word together.

The status word holds three controls:
- a saturation-mode bit, which selects clamped or wrapping signed results;
- a software field that the hardware does not interpret;
- an interrupt enable bit and a three-bit mask level, which together decide whether a requested interrupt level is accepted.

A one-shot pulse inverts the saturation mode for the next arithmetic operation only. It leaves the stored bit unchanged. Software can load the whole word directly, and that write wins over a flag update in the same cycle.

Top module: `psw_flag_unit`

## Requirements
- R1: After reset, psw_o is 16'h0000, result_o is 0, result_valid_o is 0 and irq_accept_o is 0.
- R2: When psw_we_i is high, psw_o equals psw_wdata_i one cycle later, except that bit 12 always reads 0. A direct write takes priority over a flag update from an operation in the same cycle. The operation's result is still written.
- R3: op_kind_i encodes 00 as add (a+b), 01 as subtract (a-b), and 10 or 11 as compare (a-b, no write). One cycle after op_valid_i, result_o holds the new result and result_valid_o is 1 for an add or subtract. For a compare, result_o keeps its value and result_valid_o is 0.
- R4: Full-width flags sit at bit 7 (overflow), bit 6 (carry), bit 5 (negative) and bit 4 (zero). Overflow is set when the signed 24-bit result changes sign wrongly. Carry is the carry out of bit 23 for add, or the borrow (a < b unsigned) for subtract and compare. Negative is result bit 23. Zero is set when all 24 result bits are 0.
- R5: Low-16 flags sit at bit 3 (overflow), bit 2 (carry), bit 1 (negative) and bit 0 (zero). They use the same rules applied to bits 15:0: carry or borrow out of bit 15, signed overflow at bit 15, negative from bit 15, zero when bits 15:0 are 0.
- R6: Bit 15 selects saturation. When the effective mode is saturating and an add or subtract overflows at 24 bits, the result is clamped: 24'h7FFFFF when operand a is non-negative, 24'h800000 when a is negative. The overflow and carry flags come from the unclamped operation. The negative and zero flags come from the written result. A compare never clamps.
- R7: A pulse on sat_flip_i arms an inversion of the effective saturation mode for the next operation. It does not change psw_o bit 15. Any operation disarms it, so the operation after that uses bit 15 as stored.
- R8: irq_accept_o is combinational and equals irq_req_i AND bit 11 (enable) AND (irq_level_i <= bits 10:8). A level above the mask, or a cleared enable bit, is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Start an operation this cycle |
| op_kind_i | input | 2 | 00 add, 01 subtract, 1x compare |
| op_a_i | input | 24 | Operand a |
| op_b_i | input | 24 | Operand b |
| sat_flip_i | input | 1 | Arm one-shot saturation inversion |
| psw_we_i | input | 1 | Direct status word write |
| psw_wdata_i | input | 16 | Status word write data |
| irq_req_i | input | 1 | Interrupt request present |
| irq_level_i | input | 3 | Requested interrupt level |
| result_o | output | 24 | Last written result |
| result_valid_o | output | 1 | Result written in the previous cycle |
| psw_o | output | 16 | Status word |
| irq_accept_o | output | 1 | Request accepted |

## Verification
Arithmetic results, result_valid_o and both flag groups are registered, so they are due exactly one clock after the edge that captured op_valid_i. A direct write is visible one clock after psw_we_i in the same way. irq_accept_o follows its inputs and the current status word in the same cycle. The bench changes inputs on the falling edge and samples on the next falling edge, so every registered result is read once, half a cycle after the edge that produced it. Interrupt checks are sampled after the inputs have settled, with no edge in between.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int PSW_W   = 16;
  localparam int ST_BIT  = 15;
  localparam int RSV_BIT = 12;
  localparam int IE_BIT  = 11;
  localparam int IM_LSB  = 8;

  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_CMP  = 2'b10,
    OP_CMPX = 2'b11
  } op_kind_e;

  typedef struct packed {
    logic v;
    logic c;
    logic n;
    logic z;
  } flags_t;
endpackage

// File: rtl/flag_alu.sv
module flag_alu
  import psw_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int LOW_W  = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [1:0]        kind_i,
  input  logic              sat_en_i,
  output logic [DATA_W-1:0] res_o,
  output logic              wr_o,
  output flags_t            full_o,
  output flags_t            low_o
);
  localparam int MSB = DATA_W - 1;
  localparam int LMSB = LOW_W - 1;
  localparam logic [DATA_W-1:0] SMAX = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic [DATA_W-1:0] SMIN = {1'b1, {(DATA_W-1){1'b0}}};

  logic              is_sub, is_cmp;
  logic [DATA_W:0]   full_x;
  logic [LOW_W:0]    low_x;
  logic [DATA_W-1:0] raw;
  logic              ovf_full, ovf_low, clamp;

  assign is_sub = (op_kind_e'(kind_i) != OP_ADD);
  assign is_cmp = kind_i[1];
  assign wr_o   = !is_cmp;

  always_comb begin
    if (is_sub) begin
      full_x = {1'b0, a_i} - {1'b0, b_i};
      low_x  = {1'b0, a_i[LMSB:0]} - {1'b0, b_i[LMSB:0]};
    end else begin
      full_x = {1'b0, a_i} + {1'b0, b_i};
      low_x  = {1'b0, a_i[LMSB:0]} + {1'b0, b_i[LMSB:0]};
    end
  end

  assign raw = full_x[MSB:0];

  // subtract overflows on differing signs, add on equal signs
  assign ovf_full = ((a_i[MSB] ^ b_i[MSB]) == is_sub) && (raw[MSB] != a_i[MSB]);
  assign ovf_low  = ((a_i[LMSB] ^ b_i[LMSB]) == is_sub) && (low_x[LMSB] != a_i[LMSB]);

  assign clamp = sat_en_i && ovf_full && !is_cmp;
  assign res_o = clamp ? (a_i[MSB] ? SMIN : SMAX) : raw;

  assign full_o = '{v: ovf_full, c: full_x[DATA_W], n: res_o[MSB],  z: (res_o == '0)};
  assign low_o  = '{v: ovf_low,  c: low_x[LOW_W],   n: res_o[LMSB], z: (res_o[LMSB:0] == '0)};
endmodule

// File: rtl/sat_prefix.sv
module sat_prefix (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic consume_i,
  output logic armed_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        armed_o <= 1'b0;
    else if (arm_i)     armed_o <= 1'b1;
    else if (consume_i) armed_o <= 1'b0;
  end

  // R7
  disarm_after_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    consume_i && !arm_i |=> !armed_o);
endmodule

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int IM_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ie_i,
  input  logic [IM_W-1:0] mask_i,
  input  logic            req_i,
  input  logic [IM_W-1:0] level_i,
  output logic            accept_o
);
  assign accept_o = req_i && ie_i && (level_i <= mask_i);

  // R8
  disabled_refuse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie_i |-> !accept_o);
  // R8
  above_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_i > mask_i) |-> !accept_o);
endmodule

// File: rtl/psw_flag_unit.sv
module psw_flag_unit
  import psw_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int LOW_W  = 16,
  parameter int IM_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              op_valid_i,
  input  logic [1:0]        op_kind_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic              sat_flip_i,
  input  logic              psw_we_i,
  input  logic [15:0]       psw_wdata_i,
  input  logic              irq_req_i,
  input  logic [IM_W-1:0]   irq_level_i,
  output logic [DATA_W-1:0] result_o,
  output logic              result_valid_o,
  output logic [15:0]       psw_o,
  output logic              irq_accept_o
);
  localparam logic [PSW_W-1:0] WMASK = ~(PSW_W'(1) << RSV_BIT);

  logic [PSW_W-1:0]  psw_q;
  logic [DATA_W-1:0] res_q, alu_res;
  logic              valid_q, alu_wr, flip_armed, sat_eff;
  flags_t            full_f, low_f;

  sat_prefix u_prefix (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .arm_i     (sat_flip_i),
    .consume_i (op_valid_i),
    .armed_o   (flip_armed)
  );

  assign sat_eff = psw_q[ST_BIT] ^ flip_armed;

  flag_alu #(.DATA_W(DATA_W), .LOW_W(LOW_W)) u_alu (
    .a_i      (op_a_i),
    .b_i      (op_b_i),
    .kind_i   (op_kind_i),
    .sat_en_i (sat_eff),
    .res_o    (alu_res),
    .wr_o     (alu_wr),
    .full_o   (full_f),
    .low_o    (low_f)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psw_q <= '0;
    end else if (psw_we_i) begin
      psw_q <= psw_wdata_i & WMASK;
    end else if (op_valid_i) begin
      psw_q[7:0] <= {full_f, low_f};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= op_valid_i && alu_wr;
      if (op_valid_i && alu_wr) res_q <= alu_res;
    end
  end

  irq_gate #(.IM_W(IM_W)) u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ie_i     (psw_q[IE_BIT]),
    .mask_i   (psw_q[IM_LSB +: IM_W]),
    .req_i    (irq_req_i),
    .level_i  (irq_level_i),
    .accept_o (irq_accept_o)
  );

  assign psw_o          = psw_q;
  assign result_o       = res_q;
  assign result_valid_o = valid_q;

  // R2
  direct_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psw_we_i |=> psw_o == ($past(psw_wdata_i) & 16'hEFFF));
  // R3
  cmp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && op_kind_i[1] |=> $stable(result_o) && !result_valid_o);
  // R4
  zero_nest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && !psw_we_i |=> (!psw_o[4] || psw_o[0]));
  // R7
  flip_keeps_st_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_flip_i && !psw_we_i |=> $stable(psw_o[15]));
endmodule

// File: tb/tb_psw_flag_unit.sv
module tb_psw_flag_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [1:0]  op_kind = 2'b00;
  logic [23:0] op_a = '0, op_b = '0;
  logic        sat_flip = 1'b0;
  logic        psw_we = 1'b0;
  logic [15:0] psw_wdata = '0;
  logic        irq_req = 1'b0;
  logic [2:0]  irq_level = '0;
  logic [23:0] result;
  logic        result_valid;
  logic [15:0] psw;
  logic        irq_accept;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  psw_flag_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_kind_i(op_kind),
    .op_a_i(op_a), .op_b_i(op_b), .sat_flip_i(sat_flip), .psw_we_i(psw_we),
    .psw_wdata_i(psw_wdata), .irq_req_i(irq_req), .irq_level_i(irq_level),
    .result_o(result), .result_valid_o(result_valid), .psw_o(psw),
    .irq_accept_o(irq_accept)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic        st;
    logic [23:0] a;
    logic [23:0] b;
    logic [23:0] res;
    logic [7:0]  flg;
    logic        vld;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{2'b00, 1'b0, 24'h000001, 24'h000002, 24'h000003, 8'h00, 1'b1},
    '{2'b00, 1'b0, 24'h7FFFFF, 24'h000001, 24'h800000, 8'hA5, 1'b1},
    '{2'b00, 1'b1, 24'h7FFFFF, 24'h000001, 24'h7FFFFF, 8'h86, 1'b1},
    '{2'b01, 1'b0, 24'h000000, 24'h000001, 24'hFFFFFF, 8'h66, 1'b1},
    '{2'b01, 1'b0, 24'h800000, 24'h000001, 24'h7FFFFF, 8'h86, 1'b1},
    '{2'b01, 1'b1, 24'h800000, 24'h000001, 24'h800000, 8'hA5, 1'b1},
    '{2'b10, 1'b0, 24'h123456, 24'h123456, 24'h800000, 8'h11, 1'b0},
    '{2'b00, 1'b0, 24'hFFFFFF, 24'h000001, 24'h000000, 8'h55, 1'b1},
    '{2'b00, 1'b0, 24'h008000, 24'h008000, 24'h010000, 8'h0D, 1'b1},
    '{2'b11, 1'b1, 24'h000005, 24'h000009, 24'h010000, 8'h66, 1'b0},
    '{2'b01, 1'b1, 24'h7FFFFF, 24'hFFFFFF, 24'h7FFFFF, 8'hC2, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] w);
    @(negedge clk);
    psw_we = 1'b1; psw_wdata = w;
    @(negedge clk);
    psw_we = 1'b0;
  endtask

  task automatic do_op(input logic [1:0] k, input logic [23:0] a, input logic [23:0] b);
    @(negedge clk);
    op_valid = 1'b1; op_kind = k; op_a = a; op_b = b;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic chk_irq(input logic lvl_req, input logic [2:0] lvl, input logic exp);
    irq_req = lvl_req; irq_level = lvl;
    #1;
    chk(irq_accept == exp, "R8 irq_accept", 32'(irq_accept), 32'(exp));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    irq_req = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(psw == 16'h0000, "R1 psw", 32'(psw), 32'h0);
    chk(result == 24'h0, "R1 result", 32'(result), 32'h0);
    chk(result_valid == 1'b0, "R1 valid", 32'(result_valid), 32'h0);
    chk(irq_accept == 1'b0, "R1 irq", 32'(irq_accept), 32'h0);
    irq_req = 1'b0;
    rst_n = 1'b1;

    // vector table: R3 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      do_write({TBL[i].st, 15'b0});
      do_op(TBL[i].kind, TBL[i].a, TBL[i].b);
      chk(result == TBL[i].res, $sformatf("R3 R6 result vec%0d", i), 32'(result), 32'(TBL[i].res));
      chk(result_valid == TBL[i].vld, $sformatf("R3 valid vec%0d", i), 32'(result_valid), 32'(TBL[i].vld));
      chk(psw[7:4] == TBL[i].flg[7:4], $sformatf("R4 full flags vec%0d", i), 32'(psw[7:4]), 32'(TBL[i].flg[7:4]));
      chk(psw[3:0] == TBL[i].flg[3:0], $sformatf("R5 low flags vec%0d", i), 32'(psw[3:0]), 32'(TBL[i].flg[3:0]));
      chk(psw[15] == TBL[i].st, $sformatf("R6 st kept vec%0d", i), 32'(psw[15]), 32'(TBL[i].st));
    end

    // R2 direct write, bit 12 reads 0
    do_write(16'hFFFF);
    chk(psw == 16'hEFFF, "R2 write all ones", 32'(psw), 32'hEFFF);
    // R2 write wins over flag update, result still written
    @(negedge clk);
    psw_we = 1'b1; psw_wdata = 16'h0800;
    op_valid = 1'b1; op_kind = 2'b00; op_a = 24'hFFFFFF; op_b = 24'h000001;
    @(negedge clk);
    psw_we = 1'b0; op_valid = 1'b0;
    chk(psw == 16'h0800, "R2 write priority", 32'(psw), 32'h0800);
    chk(result == 24'h0 && result_valid, "R2 result still written", 32'(result), 32'h0);

    // R7 one-shot inversion
    do_write(16'h0000);
    @(negedge clk); sat_flip = 1'b1;
    @(negedge clk); sat_flip = 1'b0;
    chk(psw[15] == 1'b0, "R7 st unchanged by flip", 32'(psw[15]), 32'h0);
    do_op(2'b00, 24'h7FFFFF, 24'h000001);
    chk(result == 24'h7FFFFF, "R7 flipped to saturate", 32'(result), 32'h7FFFFF);
    do_op(2'b00, 24'h7FFFFF, 24'h000001);
    chk(result == 24'h800000, "R7 flip consumed", 32'(result), 32'h800000);
    do_write(16'h8000);
    @(negedge clk); sat_flip = 1'b1;
    @(negedge clk); sat_flip = 1'b0;
    do_op(2'b01, 24'h800000, 24'h000001);
    chk(result == 24'h7FFFFF, "R7 flipped to wrap", 32'(result), 32'h7FFFFF);
    chk(psw[15] == 1'b1, "R7 st still set", 32'(psw[15]), 32'h1);

    // R8 interrupt acceptance: IE bit 11, mask bits 10:8
    do_write(16'h0B00);
    @(negedge clk);
    chk_irq(1'b1, 3'd3, 1'b1);
    chk_irq(1'b1, 3'd4, 1'b0);
    chk_irq(1'b1, 3'd0, 1'b1);
    chk_irq(1'b0, 3'd0, 1'b0);
    do_write(16'h0300);
    @(negedge clk);
    chk_irq(1'b1, 3'd0, 1'b0);
    do_write(16'h0F00);
    @(negedge clk);
    chk_irq(1'b1, 3'd7, 1'b1);
    irq_req = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule